// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them by a fixed priority and hands the processor one request at a time. Software reaches it through a byte-wide port with two addresses: a command address and a data address. Three 8-bit registers hold the state. The request register records lines that have seen a rising edge. The in-service register records lines that have been acknowledged and not yet retired. The mask register blocks single lines.

The controller stays inert until it has been programmed. A command write with bit 4 set, normally 0x11, starts the setup sequence. The next three data writes give, in this order, the vector base, the cascade word and the mode word. After that the command address takes end-of-interrupt and readback-select commands, and the data address holds the mask. On acknowledge the block returns a vector, which is the base plus the number of the winning line.

Several controllers can be chained. A master names the line of a slave on a 3-bit cascade bus during acknowledge and lets that slave supply the vector. A slave answers an acknowledge only when the cascade bus carries its own identity.

Top module: `prio_intc`

## Requirements
- R1: After reset, int_out and vec_oe are 0, the mask register reads 0xFF at the data address and the command address reads 0x00. Before the setup sequence ends, an acknowledge produces no vector.
- R2: A command write with bit 4 set clears the mask and in-service registers and selects the request register for command reads. The next three data writes are taken as vector base, cascade word and mode word, and none of them changes the mask register.
- R3: A rising edge on irq_in[n] sets request bit n, and int_out can rise at the same clock edge. If the line falls before acknowledge, the bit clears at the next edge.
- R4: After setup, a data write loads the mask register and a data read returns it. A line whose mask bit is 1 still sets its request bit but never raises int_out.
- R5: Priority is fixed with line 0 highest. int_out is 1 only when some unmasked request bit has a lower index than every set in-service bit.
- R6: An acknowledge (inta high for one cycle) moves the winning request, which is the lowest-index eligible one, from the request register to the in-service register. In the next cycle vec_oe is 1 for one cycle and vec_out equals base + n.
- R7: The command 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R8: Command 0x0B makes command-address reads return the in-service register, and 0x0A makes them return the request register. The choice persists across other commands.
- R9: When mode-word bit 1 is set (auto-EOI), an acknowledge returns the vector but leaves the in-service register unchanged.
- R10: An acknowledge with no eligible request returns base + 7 and leaves the in-service register unchanged. This holds even when line 7 is masked.
- R11: In master mode (slave_mode = 0), when the winning line n has cascade-word bit n set, cas_oe is 1 and cas_out equals n during the acknowledge cycle. In-service bit n is set and vec_oe stays 0.
- R12: In slave mode (slave_mode = 1), an acknowledge is served only when cas_in equals cascade-word bits 2:0. Otherwise no vector is given and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we | input | 1 | Register write strobe |
| a0 | input | 1 | Address: 0 = command, 1 = data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the address on a0 |
| irq_in | input | 8 | Interrupt request lines, rising-edge sensed |
| inta | input | 1 | Acknowledge, one cycle per acknowledge |
| slave_mode | input | 1 | 1 = act as slave in a cascade |
| cas_in | input | 3 | Cascade identity seen by a slave |
| cas_out | output | 3 | Line number forwarded by a master |
| cas_oe | output | 1 | cas_out is valid |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned for the last acknowledge |
| vec_oe | output | 1 | vec_out is valid |

## Verification
The spurious acknowledge is the hardest case to reach from the ports. A request has to be seen and then drop away before the acknowledge arrives. The bench raises a line, lowers it, waits until the request bit has cleared, and then pulses inta. It also repeats this with line 7 masked. The in-service ceiling needs a lower-priority request pending while a higher line is in service, so directed sequences stack acknowledges on lines 3 and 1 and retire them out of order. Random mask and request patterns then cover the arbitration broadly.

// File: rtl/prio_intc_pkg.sv
// Shared sizes and the setup-sequence state type for the interrupt controller.
package prio_intc_pkg;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_OFF,     // never programmed
        ST_W2,      // expecting vector base
        ST_W3,      // expecting cascade word
        ST_W4,      // expecting mode word
        ST_RUN      // operational
    } cfg_state_t;
endpackage

// File: rtl/intc_cfg.sv
// Register-port decoder and setup sequencer.
// Holds mask, vector base, cascade word, auto-EOI flag and readback select.
// Assumes one write per we pulse; reads have no side effects.
module intc_cfg
    import prio_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              a0,
    input  logic [DATA_W-1:0] wdata,
    output logic [LINES-1:0]  imr,
    output logic [DATA_W-1:0] base,
    output logic [DATA_W-1:0] casc,
    output logic              aeoi,
    output logic              rd_isr,
    output logic              ready,
    output logic              init_clr,
    output logic              eoi_req,
    output logic [IDX_W-1:0]  eoi_line
);
    cfg_state_t st;
    logic       cmd_wr, dat_wr, in_setup;

    // Decode strobes for this cycle's write
    always_comb begin
        cmd_wr   = we && !a0;
        dat_wr   = we && a0;
        ready    = (st == ST_RUN);
        in_setup = (st == ST_W2) || (st == ST_W3) || (st == ST_W4);
        init_clr = cmd_wr && wdata[4];
        eoi_req  = cmd_wr && ready && (wdata[7:3] == 5'b01100);
        eoi_line = wdata[IDX_W-1:0];
    end

    // Setup sequencer and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_OFF;
            imr    <= '1;
            base   <= '0;
            casc   <= '0;
            aeoi   <= 1'b0;
            rd_isr <= 1'b0;
        end else if (init_clr) begin
            st     <= ST_W2;
            imr    <= '0;
            rd_isr <= 1'b0;
        end else if (cmd_wr && ready && wdata[4:3] == 2'b01 && wdata[1]) begin
            rd_isr <= wdata[0];
        end else if (dat_wr) begin
            case (st)
                ST_W2:   begin base <= wdata; st <= ST_W3; end
                ST_W3:   begin casc <= wdata; st <= ST_W4; end
                ST_W4:   begin aeoi <= wdata[1]; st <= ST_RUN; end
                ST_RUN:  imr <= wdata;
                default: ;
            endcase
        end
    end

    AST_SETUP_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && in_setup) |=> $stable(imr)); // R2
    AST_START_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> (imr == '0 && !rd_isr)); // R2
endmodule

// File: rtl/intc_req.sv
// Request register: rising-edge capture per line, held while the line stays high.
// A bit clears when its line falls or when the acknowledge logic takes it.
module intc_req
    import prio_intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] ack_clr,
    output logic [LINES-1:0] irr
);
    logic [LINES-1:0] prev;

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            // Edge capture and hold for one request line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev[g] <= 1'b0;
                    irr[g]  <= 1'b0;
                end else begin
                    prev[g] <= irq_in[g];
                    irr[g]  <= ((irr[g] && irq_in[g]) || (irq_in[g] && !prev[g])) && !ack_clr[g];
                end
            end
        end
    endgenerate

    AST_NO_REQ_ON_LOW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irr & ~$past(irq_in)) == '0)); // R3
endmodule

// File: rtl/intc_resolve.sv
// Priority resolver, in-service register and acknowledge sequencing.
// Fixed priority, line 0 highest. The vector is registered one cycle after inta.
// Cascade forwarding is combinational during the acknowledge cycle.
module intc_resolve
    import prio_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irr,
    input  logic [LINES-1:0]  imr,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] casc,
    input  logic              aeoi,
    input  logic              ready,
    input  logic              slave_mode,
    input  logic              inta,
    input  logic [IDX_W-1:0]  cas_in,
    input  logic              init_clr,
    input  logic              eoi_req,
    input  logic [IDX_W-1:0]  eoi_line,
    output logic [LINES-1:0]  isr,
    output logic [LINES-1:0]  ack_clr,
    output logic              int_out,
    output logic [IDX_W-1:0]  cas_out,
    output logic              cas_oe,
    output logic [DATA_W-1:0] vec_out,
    output logic              vec_oe
);
    localparam logic [IDX_W-1:0] SPUR_LINE = IDX_W'(LINES - 1);

    logic [LINES-1:0] allowed, elig, isr_nxt;
    logic             seen, win_valid, take, fwd, selected;
    logic [IDX_W-1:0] win_idx;

    // Lines ranked above every in-service line
    always_comb begin
        seen = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            allowed[i] = !(seen || isr[i]);
            seen       = seen || isr[i];
        end
    end

    // Pick the lowest-index eligible request
    always_comb begin
        elig      = irr & ~imr & allowed;
        win_valid = |elig;
        win_idx   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (elig[i]) win_idx = IDX_W'(i);
        end
    end

    // Acknowledge qualification and cascade forwarding
    always_comb begin
        selected = slave_mode ? (cas_in == casc[IDX_W-1:0]) : 1'b1;
        take     = ready && inta && selected;
        fwd      = !slave_mode && win_valid && casc[win_idx];
        cas_out  = win_idx;
        cas_oe   = ready && inta && fwd;
        int_out  = ready && win_valid;
        ack_clr  = '0;
        if (take && win_valid) ack_clr[win_idx] = 1'b1;
    end

    // Next in-service value: retire first, then record the acknowledged line
    always_comb begin
        isr_nxt = isr;
        if (eoi_req) isr_nxt[eoi_line] = 1'b0;
        if (take && win_valid && !aeoi) isr_nxt[win_idx] = 1'b1;
    end

    // In-service register
    always_ff @(posedge clk) begin
        if (!rst_n)        isr <= '0;
        else if (init_clr) isr <= '0;
        else               isr <= isr_nxt;
    end

    // Registered vector output, one cycle per served acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_oe  <= 1'b0;
            vec_out <= '0;
        end else begin
            vec_oe <= take && !fwd;
            if (take) vec_out <= base + DATA_W'(win_valid ? win_idx : SPUR_LINE);
        end
    end

    AST_VEC_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> $past(inta)); // R6
    AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !inta && !init_clr) |=> !isr[$past(eoi_line)]); // R7
    AST_SPUR_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !win_valid && !eoi_req && !init_clr) |=> $stable(isr)); // R10
    AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (take && aeoi && !eoi_req && !init_clr) |=> $stable(isr)); // R9
    AST_UNSELECTED_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && slave_mode && !selected) |=> !vec_oe); // R12
endmodule

// File: rtl/prio_intc.sv
// Eight-line programmable priority interrupt controller, top level.
// Connects the register port, request capture and resolver, and muxes readback.
// Assumes synchronous active-low reset and single-cycle inta pulses.
module prio_intc
    import prio_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              a0,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [LINES-1:0]  irq_in,
    input  logic              inta,
    input  logic              slave_mode,
    input  logic [IDX_W-1:0]  cas_in,
    output logic [IDX_W-1:0]  cas_out,
    output logic              cas_oe,
    output logic              int_out,
    output logic [DATA_W-1:0] vec_out,
    output logic              vec_oe
);
    logic [LINES-1:0]  imr, irr, isr, ack_clr;
    logic [DATA_W-1:0] base, casc;
    logic              aeoi, rd_isr, ready, init_clr, eoi_req;
    logic [IDX_W-1:0]  eoi_line;

    intc_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(we), .a0(a0), .wdata(wdata),
        .imr(imr), .base(base), .casc(casc), .aeoi(aeoi), .rd_isr(rd_isr),
        .ready(ready), .init_clr(init_clr), .eoi_req(eoi_req), .eoi_line(eoi_line)
    );

    intc_req u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_clr(ack_clr), .irr(irr)
    );

    intc_resolve u_res (
        .clk(clk), .rst_n(rst_n), .irr(irr), .imr(imr), .base(base), .casc(casc),
        .aeoi(aeoi), .ready(ready), .slave_mode(slave_mode), .inta(inta),
        .cas_in(cas_in), .init_clr(init_clr), .eoi_req(eoi_req), .eoi_line(eoi_line),
        .isr(isr), .ack_clr(ack_clr), .int_out(int_out), .cas_out(cas_out),
        .cas_oe(cas_oe), .vec_out(vec_out), .vec_oe(vec_oe)
    );

    // Readback mux for the addressed register
    always_comb begin
        if (a0)          rdata = imr;
        else if (rd_isr) rdata = isr;
        else             rdata = irr;
    end

    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (|(irr & ~imr))); // R4
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0, a0 = 1'b0, inta = 1'b0, slave_mode = 1'b0;
    logic [7:0] wdata = '0, irq_in = '0;
    logic [2:0] cas_in = '0;
    logic [7:0] rdata, vec_out;
    logic [2:0] cas_out;
    logic       cas_oe, int_out, vec_oe;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    prio_intc u_dut (
        .clk(clk), .rst_n(rst_n), .we(we), .a0(a0), .wdata(wdata), .rdata(rdata),
        .irq_in(irq_in), .inta(inta), .slave_mode(slave_mode), .cas_in(cas_in),
        .cas_out(cas_out), .cas_oe(cas_oe), .int_out(int_out),
        .vec_out(vec_out), .vec_oe(vec_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; a0 = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk); a0 = a; #1 v = rdata;
    endtask

    task automatic ack(output logic [7:0] v, output logic voe,
                       output logic [2:0] co, output logic coe);
        @(negedge clk); inta = 1'b1; #1 co = cas_out; coe = cas_oe;
        @(negedge clk); inta = 1'b0; #1 v = vec_out; voe = vec_oe;
    endtask

    task automatic setup(input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
        wr(1'b0, 8'h11); wr(1'b1, b); wr(1'b1, c); wr(1'b1, m);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] lowest(input logic [7:0] p);
        logic [7:0] r = 8'hFF;
        for (int i = 7; i >= 0; i--) if (p[i]) r = 8'(i);
        return r;
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, m, p, e;
        logic       voe, coe;
        logic [2:0] co;
        void'($urandom(32'd1234));

        cyc(3); rst_n = 1'b1; cyc(1);
        // R1: reset state
        chk("R1 int_out", {7'd0, int_out}, 8'h00);
        chk("R1 vec_oe", {7'd0, vec_oe}, 8'h00);
        rd(1'b1, v); chk("R1 mask reset", v, 8'hFF);
        rd(1'b0, v); chk("R1 cmd read", v, 8'h00);
        ack(v, voe, co, coe); chk("R1 ack ignored", {7'd0, voe}, 8'h00);

        // R2: setup words do not reach the mask
        setup(8'h20, 8'h04, 8'h01);
        rd(1'b1, v); chk("R2 mask after setup", v, 8'h00);

        // R3: edge capture and drop
        @(negedge clk); irq_in = 8'h20; cyc(1);
        chk("R3 int after edge", {7'd0, int_out}, 8'h01);
        rd(1'b0, v); chk("R3 irr set", v, 8'h20);
        @(negedge clk); irq_in = 8'h00; cyc(1);
        rd(1'b0, v); chk("R3 irr drop", v, 8'h00);
        chk("R3 int drop", {7'd0, int_out}, 8'h00);

        // R10: spurious acknowledge, unmasked then with line 7 masked
        @(negedge clk); irq_in = 8'h10; cyc(1);
        @(negedge clk); irq_in = 8'h00; cyc(2);
        ack(v, voe, co, coe);
        chk("R10 spur vec", v, 8'h27); chk("R10 spur oe", {7'd0, voe}, 8'h01);
        wr(1'b0, 8'h0B); rd(1'b0, v); chk("R10 isr kept", v, 8'h00);
        wr(1'b0, 8'h0A);
        wr(1'b1, 8'h80);
        ack(v, voe, co, coe); chk("R10 spur masked7", v, 8'h27);

        // R4: masked line records but stays silent
        wr(1'b1, 8'h08); rd(1'b1, v); chk("R4 mask readback", v, 8'h08);
        @(negedge clk); irq_in = 8'h08; cyc(1);
        chk("R4 masked silent", {7'd0, int_out}, 8'h00);
        rd(1'b0, v); chk("R4 irr records", v, 8'h08);
        wr(1'b1, 8'h00); chk("R4 unmask raises", {7'd0, int_out}, 8'h01);

        // R6 R5 R7 R8: nesting under the in-service ceiling
        ack(v, voe, co, coe); chk("R6 vec line3", v, 8'h23);
        chk("R6 vec_oe", {7'd0, voe}, 8'h01);
        rd(1'b0, v); chk("R6 irr cleared", v, 8'h00);
        wr(1'b0, 8'h0B); rd(1'b0, v); chk("R6 isr set", v, 8'h08);
        @(negedge clk); irq_in = 8'h28; cyc(1);
        chk("R5 lower blocked", {7'd0, int_out}, 8'h00);
        @(negedge clk); irq_in = 8'h2A; cyc(1);
        chk("R5 higher passes", {7'd0, int_out}, 8'h01);
        ack(v, voe, co, coe); chk("R6 vec line1", v, 8'h21);
        rd(1'b0, v); chk("R8 isr persists", v, 8'h0A);
        wr(1'b0, 8'h61); rd(1'b0, v); chk("R7 eoi1 only", v, 8'h08);
        chk("R5 still blocked", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h63); rd(1'b0, v); chk("R8 isr after eoi", v, 8'h00);
        chk("R5 released", {7'd0, int_out}, 8'h01);
        ack(v, voe, co, coe); chk("R6 vec line5", v, 8'h25);
        wr(1'b0, 8'h65);
        wr(1'b0, 8'h0A); rd(1'b0, v); chk("R8 irr selected", v, 8'h00);
        @(negedge clk); irq_in = 8'h00; cyc(2);

        // R11: master forwards a cascaded line
        @(negedge clk); irq_in = 8'h04; cyc(1);
        ack(v, voe, co, coe);
        chk("R11 cas_oe", {7'd0, coe}, 8'h01); chk("R11 cas_out", {5'd0, co}, 8'h02);
        chk("R11 no vector", {7'd0, voe}, 8'h00);
        wr(1'b0, 8'h0B); rd(1'b0, v); chk("R11 isr set", v, 8'h04);
        wr(1'b0, 8'h62);
        @(negedge clk); irq_in = 8'h00; cyc(2);

        // R9: auto-EOI
        setup(8'h30, 8'h00, 8'h03);
        @(negedge clk); irq_in = 8'h40; cyc(1);
        ack(v, voe, co, coe); chk("R9 vec", v, 8'h36);
        wr(1'b0, 8'h0B); rd(1'b0, v); chk("R9 isr clear", v, 8'h00);
        @(negedge clk); irq_in = 8'h00; cyc(2);

        // R12: slave answers only its own identity
        @(negedge clk); slave_mode = 1'b1;
        setup(8'h70, 8'h02, 8'h01);
        @(negedge clk); irq_in = 8'h01; cas_in = 3'd3; cyc(1);
        ack(v, voe, co, coe); chk("R12 other id silent", {7'd0, voe}, 8'h00);
        wr(1'b0, 8'h0B); rd(1'b0, v); chk("R12 isr untouched", v, 8'h00);
        @(negedge clk); cas_in = 3'd2;
        ack(v, voe, co, coe); chk("R12 own id vec", v, 8'h70);
        rd(1'b0, v); chk("R12 isr set", v, 8'h01);
        @(negedge clk); irq_in = 8'h00; slave_mode = 1'b0; cyc(2);

        // Random mask/request patterns, master without cascade
        setup(8'h40, 8'h00, 8'h01);
        for (int it = 0; it < 40; it++) begin
            m = 8'($urandom); p = 8'($urandom);
            wr(1'b1, m); rd(1'b1, v); chk("R4 rand mask", v, m);
            @(negedge clk); irq_in = p; cyc(1);
            e = p & ~m;
            chk("R5 rand int", {7'd0, int_out}, {7'd0, |e});
            ack(v, voe, co, coe);
            if (|e) begin
                chk("R6 rand vec", v, 8'h40 + lowest(e));
                wr(1'b0, 8'h60 | lowest(e));
            end else begin
                chk("R10 rand spur", v, 8'h47);
            end
            @(negedge clk); irq_in = 8'h00; cyc(2);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule